// File: doc/BRIEF.md
# Single-Wire Identification Responder

This block is a clocked, fully synchronous model of a line-powered identification device that sits on an open-drain single-wire bus. A free-running 1 µs enable (`tick_us`) is its timebase. The raw line level enters through a two-flop synchronizer. The block watches the durations of the low periods on the line to find bus resets. After each reset it answers with a presence pulse. It then decodes an 8-bit command from write slots. When the command is the read code, it plays out a 64-bit identity image one bit per read slot. It shows a 0 by pulling the line low and a 1 by leaving the line released.

The identity image is built from parameters. Bits 0 to 7 hold a family byte, bits 8 to 55 hold a 48-bit serial number, and bits 56 to 63 hold a check byte computed over the lower 56 bits. The only output toward the line is a pull-down enable. The surrounding pad must turn that enable into an open-drain driver and feed the resolved line back to `bus_in`.

The bus master sets the pace of every bit through its slots, so there is no handshake and no back-pressure at the block's edge. Three plain status pins report the command outcome and slot framing errors.

Top module: `owid_responder`

## Requirements
- R1: A line low for at least RST_MIN_US (480) ticks is a bus reset, whatever the state. It aborts a command or playback in progress and clears `cmd_ok` and `cmd_rejected`. A low of 300 ticks is not a reset.
- R2: After the line returns high following a bus reset, `pull_low` rises PRES_DLY_US (30) ticks later and stays high for exactly PRES_LEN_US (120) ticks. The whole pulse ends inside the 480-tick recovery window.
- R3: A slot begins at a falling edge. In a write slot the line is sampled SAMPLE_US (30) ticks after that edge: high gives a 1 and low gives a 0.
- R4: The command is 8 bits, least significant bit first. The value 0x0F sets `cmd_ok`, and playback starts at image bit 0.
- R5: Any other command value sets `cmd_rejected`. Until the next bus reset the block then leaves the line released in every slot.
- R6: The image is sent in this order: bits 0–7 are the family byte (0x81), bits 8–55 the serial number LSB first, and bits 56–63 the check byte. The check byte is the CRC with polynomial x^8+x^5+x^4+1, run LSB first from a zero seed over image bits 0–55.
- R7: In a read slot, a 0 bit asserts `pull_low` from the slot start until HOLD0_US (30) ticks have passed. A 1 bit leaves `pull_low` low, so the master sees the line high 13 ticks into the slot.
- R8: After bit 63, the next read slot returns bit 0 again, and this repeats without end until a bus reset.
- R9: A low longer than SLOT_MAX_US (120) ticks but shorter than 480 gives a one-cycle `frame_err` pulse when the line rises. That slot changes neither the command bits nor the playback position.
- R10: After `rst_n` the block is idle. It ignores all slots, with `pull_low`, `cmd_ok` and `cmd_rejected` all low, until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle enable every microsecond |
| bus_in | input | 1 | Raw resolved line level (asynchronous) |
| pull_low | output | 1 | Pull-down enable for the open-drain driver |
| cmd_ok | output | 1 | Read command accepted, playback active |
| cmd_rejected | output | 1 | Unknown command, muted until bus reset |
| frame_err | output | 1 | One-cycle pulse for an over-long slot |

## Verification
Every line event reaches the control state three clocks after it appears on `bus_in`: two for the synchronizer and one for the state register. With one tick per clock, a read-0 pull-down is therefore on from the third clock after the master's falling edge until about the thirty-third. The bench samples read data thirteen clocks into each slot, well inside that span.

The presence pulse starts about thirty-two clocks after the master releases a reset. The bench logs every clock of the 480-clock window and checks both the start and the exact 120-clock length. Command bits are committed a few clocks after the 30-tick sample point. Status flags and the frame-error pulse count are therefore read only after a slot's recovery time has passed, never at an edge.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLOW,
    ST_PWAIT,
    ST_PDRIVE,
    ST_CMD,
    ST_SEND,
    ST_MUTE
  } ow_state_e;

  // Reflected CRC-8, polynomial x^8+x^5+x^4+1, zero seed, data LSB first.
  function automatic logic [7:0] ow_crc8(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/owid_linemon.sv
module owid_linemon #(
  parameter int LOW_MAX = 480,
  localparam int LW = $clog2(LOW_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          bus_in,
  output logic          line_hi,
  output logic          fell,
  output logic          rose,
  output logic [LW-1:0] low_time
);

  logic [1:0] sync_q;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      prev_q   <= 1'b1;
      low_time <= '0;
    end else begin
      sync_q <= {sync_q[0], bus_in};
      prev_q <= sync_q[1];
      if (sync_q[1])
        low_time <= '0;
      else if (tick_us && low_time != LW'(LOW_MAX))
        low_time <= low_time + 1'b1;
    end
  end

  assign line_hi = sync_q[1];
  assign fell    = prev_q & ~sync_q[1];
  assign rose    = ~prev_q & sync_q[1];

  // low_time restarts at every slot start
  assert_low_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prev_q) |-> (low_time == '0));

endmodule

// File: rtl/owid_romsel.sv
module owid_romsel #(
  parameter logic [7:0]  FAMILY    = 8'h81,
  parameter logic [47:0] SERIAL    = 48'h0000_5A3C_19E7,
  parameter bit          CALC_CRC  = 1'b1,
  parameter logic [7:0]  CRC_FIXED = 8'h00,
  parameter int          IMG_BITS  = 64,
  localparam int IW = $clog2(IMG_BITS)
) (
  input  logic [IW-1:0] idx,
  output logic          bit_o
);

  logic [7:0]          crc_v;
  logic [IMG_BITS-1:0] image;

  generate
    if (CALC_CRC) begin : g_crc_calc
      localparam logic [7:0] CRC_C = owid_pkg::ow_crc8({SERIAL, FAMILY});
      assign crc_v = CRC_C;
    end else begin : g_crc_fixed
      assign crc_v = CRC_FIXED;
    end
  endgenerate

  assign image = {crc_v, SERIAL, FAMILY};
  assign bit_o = image[idx];

endmodule

// File: rtl/owid_responder.sv
module owid_responder
  import owid_pkg::*;
#(
  parameter logic [7:0]  FAMILY      = 8'h81,
  parameter logic [47:0] SERIAL      = 48'h0000_5A3C_19E7,
  parameter bit          CALC_CRC    = 1'b1,
  parameter logic [7:0]  CRC_FIXED   = 8'h00,
  parameter logic [7:0]  READ_CMD    = 8'h0F,
  parameter int          RST_MIN_US  = 480,
  parameter int          PRES_DLY_US = 30,
  parameter int          PRES_LEN_US = 120,
  parameter int          SAMPLE_US   = 30,
  parameter int          HOLD0_US    = 30,
  parameter int          SLOT_MAX_US = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic bus_in,
  output logic pull_low,
  output logic cmd_ok,
  output logic cmd_rejected,
  output logic frame_err
);

  localparam int IMG_BITS = 64;
  localparam int LW       = $clog2(RST_MIN_US + 1);
  localparam int IW       = $clog2(IMG_BITS);
  localparam int CMD_BITS = 8;
  localparam int CW       = $clog2(CMD_BITS);

  ow_state_e     state;
  logic [LW-1:0] tcnt;
  logic [LW-1:0] low_time;
  logic          line_hi, fell, rose;
  logic          slot_on, sampled, samp_val, slot_bad;
  logic [7:0]    cmd_sh;
  logic [7:0]    cmd_next;
  logic [CW-1:0] bcnt;
  logic [IW-1:0] idx;
  logic          rom_bit;
  logic          reset_hit, commit;

  owid_linemon #(.LOW_MAX(RST_MIN_US)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .bus_in   (bus_in),
    .line_hi  (line_hi),
    .fell     (fell),
    .rose     (rose),
    .low_time (low_time)
  );

  owid_romsel #(
    .FAMILY    (FAMILY),
    .SERIAL    (SERIAL),
    .CALC_CRC  (CALC_CRC),
    .CRC_FIXED (CRC_FIXED),
    .IMG_BITS  (IMG_BITS)
  ) u_rom (
    .idx   (idx),
    .bit_o (rom_bit)
  );

  assign reset_hit = !line_hi && (low_time == LW'(RST_MIN_US)) && (state != ST_PDRIVE);
  assign commit    = slot_on && sampled && line_hi && !slot_bad;
  assign cmd_next  = {samp_val, cmd_sh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      slot_on   <= 1'b0;
      sampled   <= 1'b0;
      samp_val  <= 1'b0;
      slot_bad  <= 1'b0;
      cmd_sh    <= '0;
      bcnt      <= '0;
      idx       <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (tick_us && tcnt != LW'(RST_MIN_US))
        tcnt <= tcnt + 1'b1;
      if (reset_hit) begin
        state   <= ST_RSTLOW;
        slot_on <= 1'b0;
      end else begin
        case (state)
          ST_RSTLOW: if (line_hi) begin
            state <= ST_PWAIT;
            tcnt  <= '0;
          end
          ST_PWAIT: if (tick_us && tcnt == LW'(PRES_DLY_US - 1)) begin
            state <= ST_PDRIVE;
            tcnt  <= '0;
          end
          ST_PDRIVE: if (tick_us && tcnt == LW'(PRES_LEN_US - 1)) begin
            state   <= ST_CMD;
            tcnt    <= '0;
            bcnt    <= '0;
            slot_on <= 1'b0;
          end
          ST_CMD, ST_SEND: begin
            if (fell) begin
              slot_on  <= 1'b1;
              sampled  <= 1'b0;
              slot_bad <= 1'b0;
              tcnt     <= '0;
            end else if (slot_on) begin
              if (tick_us && !sampled && tcnt == LW'(SAMPLE_US - 1)) begin
                sampled  <= 1'b1;
                samp_val <= line_hi;
              end
              if (!line_hi && low_time > LW'(SLOT_MAX_US))
                slot_bad <= 1'b1;
              if (line_hi && slot_bad) begin
                slot_on   <= 1'b0;
                frame_err <= 1'b1;
              end else if (commit) begin
                slot_on <= 1'b0;
                if (state == ST_CMD) begin
                  cmd_sh <= cmd_next;
                  bcnt   <= bcnt + 1'b1;
                  if (bcnt == CW'(CMD_BITS - 1)) begin
                    state <= (cmd_next == READ_CMD) ? ST_SEND : ST_MUTE;
                    idx   <= '0;
                  end
                end else begin
                  idx <= idx + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_low = (state == ST_PDRIVE) ||
                    (state == ST_SEND && slot_on && !rom_bit && tcnt < LW'(HOLD0_US));
  assign cmd_ok       = (state == ST_SEND);
  assign cmd_rejected = (state == ST_MUTE);

  assert_reset_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_hi && low_time == LW'(RST_MIN_US) && state != ST_PDRIVE) |=> (state == ST_RSTLOW));

  assert_presence_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDRIVE) |-> (tcnt < LW'(PRES_LEN_US)));

  assert_mute_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTE) |-> !pull_low);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!pull_low && !cmd_ok && !cmd_rejected));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && commit && idx == '1) |=> (idx == '0));

  assert_frame_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(slot_bad) && rose || $past(slot_bad) && line_hi));

endmodule

// File: tb/owid_responder_tb.sv
module owid_responder_tb_top;

  localparam logic [47:0] SER = 48'h0000_5A3C_19E7;
  localparam logic [7:0]  FAM = 8'h81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic m_low = 1'b0;
  wire  line;
  logic pull_low, cmd_ok, cmd_rejected, frame_err;

  int n_chk = 0;
  int n_bad = 0;
  int fe_count = 0;

  always #2 clk = ~clk;

  assign line = !(m_low || pull_low);

  owid_responder #(.FAMILY(FAM), .SERIAL(SER)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_us      (tick_us),
    .bus_in       (line),
    .pull_low     (pull_low),
    .cmd_ok       (cmd_ok),
    .cmd_rejected (cmd_rejected),
    .frame_err    (frame_err)
  );

  always @(posedge clk) if (frame_err) fe_count <= fe_count + 1;

  localparam int NV = 5;
  localparam logic [7:0] VCMD [NV] = '{8'h0F, 8'hF0, 8'h0E, 8'h8F, 8'h1F};
  localparam logic [7:0] VEXP [NV] = '{8'h81, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam bit         VOK  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c;
    logic       in;
    c = '0;
    for (int i = 0; i < 56; i++) begin
      in = d[i] ^ c[0];
      c  = {in, c[7], c[6], c[5], c[4] ^ in, c[3] ^ in, c[2], c[1]};
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_reset(input int low_len, output int pstart, output int plen);
    m_low = 1'b1; hold(low_len); m_low = 1'b0;
    pstart = -1; plen = 0;
    for (int t = 0; t < 480; t++) begin
      @(negedge clk);
      if (pull_low) begin
        if (pstart < 0) pstart = t;
        plen++;
      end
    end
  endtask

  task automatic wr_bit(input bit b);
    m_low = 1'b1; hold(b ? 6 : 70); m_low = 1'b0; hold(b ? 80 : 16);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic rd_bits(input int n, output logic [63:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      m_low = 1'b1; hold(6); m_low = 1'b0; hold(7);
      v[i] = line;
      hold(60);
    end
  endtask

  task automatic long_low(input int n);
    m_low = 1'b1; hold(n); m_low = 1'b0; hold(20);
  endtask

  task automatic std_reset(input string req);
    int ps, pl;
    bus_reset(500, ps, pl);
    chk({req, " presence start in 20..60"}, 64'(ps >= 20 && ps <= 60), 64'd1);
    chk({req, " presence length"}, 64'(pl), 64'd120);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [63:0] img;
    int fe0;
    img = {ref_crc({SER, FAM}), SER, FAM};

    hold(5);
    chk("R10 reset pull_low", 64'(pull_low), 64'd0);
    chk("R10 reset cmd_ok", 64'(cmd_ok), 64'd0);
    chk("R10 reset cmd_rejected", 64'(cmd_rejected), 64'd0);
    rst_n = 1'b1;
    hold(5);

    // R10: slots before any bus reset are ignored
    wr_byte(8'h0F);
    rd_bits(8, v);
    chk("R10 idle read stays released", v, 64'hFF);
    chk("R10 idle cmd_ok", 64'(cmd_ok), 64'd0);

    // Vector table: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      std_reset("R2");
      wr_byte(VCMD[k]);
      chk("R4 cmd_ok for vector", 64'(cmd_ok), 64'(VOK[k]));
      chk("R5 cmd_rejected for vector", 64'(cmd_rejected), 64'(!VOK[k]));
      rd_bits(8, v);
      chk(VOK[k] ? "R3 first byte" : "R5 muted byte", v, 64'(VEXP[k]));
    end

    // R6 R7 full image, R8 wrap
    std_reset("R2");
    wr_byte(8'h0F);
    rd_bits(64, v);
    chk("R6 R7 full image", v, img);
    rd_bits(8, v);
    chk("R8 wrap to bit 0", v, 64'(FAM));

    // R1 reset mid-playback
    std_reset("R2");
    wr_byte(8'h0F);
    rd_bits(20, v);
    chk("R7 partial image", v, img & 64'hFFFFF);
    std_reset("R1");
    chk("R1 cmd_ok cleared", 64'(cmd_ok), 64'd0);
    wr_byte(8'h0F);
    rd_bits(8, v);
    chk("R1 restart from bit 0", v, 64'(FAM));

    // R9 framing error inside the command
    std_reset("R2");
    fe0 = fe_count;
    wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b1);
    long_low(200);
    chk("R9 frame_err pulse in command", 64'(fe_count - fe0), 64'd1);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b0); wr_bit(1'b0);
    chk("R9 bad slot discarded, command accepted", 64'(cmd_ok), 64'd1);

    // R1/R9: 300-tick low during playback is not a reset
    fe0 = fe_count;
    long_low(300);
    chk("R9 frame_err pulse in playback", 64'(fe_count - fe0), 64'd1);
    chk("R1 short low not a reset", 64'(cmd_ok), 64'd1);
    rd_bits(8, v);
    chk("R9 playback position kept", v, 64'(FAM));

    // R5 mute then reset recovers
    std_reset("R2");
    wr_byte(8'h3C);
    rd_bits(4, v);
    chk("R5 muted reads released", v, 64'hF);
    std_reset("R1");
    chk("R1 rejected cleared", 64'(cmd_rejected), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule